// File: doc/BRIEF.md
# DRAM Chip-Select Window Decoder

This block steers CPU physical addresses onto a small set of DRAM chip-select windows. Each window has two write-only configuration registers: one giving the window's base (a 16 MB aligned address that may reach past the 4 GB line) and one giving its enable, its chip-select number and its length in 16 MB granules. A lookup address on `lk_addr` is compared against every enabled window. The lowest-indexed match drives a one-hot window select, the window index, the chip-select number stored for that window, and a bus attribute. The attribute is an active-low one-hot code of the window index in its low nibble, with a separate coherency flag in bit 4. A miss drives all of these to zero and raises `miss`.

The lookup result is registered and appears one clock after the address is presented. It is always computed from the window registers as they stood before that same clock edge. Alongside the lookup path, the block continuously reports how many enabled windows lie wholly within the 32-bit address space. It also lists their indices in ascending order, which lets DMA-capable devices learn which DRAM windows they can reach.

Top module: `dram_cs_decoder`

## Requirements
- R1: After reset every window is disabled: `miss` is 1, `hit_onehot`, `hit_idx`, `hit_cs` and `hit_attr` are 0, and `reach_cnt` and `reach_list` are 0.
- R2: A write with `cfg_addr` = n*8 updates window n's base register, and a write with `cfg_addr` = n*8+4 updates its size register (n = 0..3); `cfg_addr[1:0]` is ignored.
- R3: In a base write, data bits 31:24 become address bits 31:24 and data bits 3:0 become address bits 35:32; address bits 23:0 of the base are zero, and data bits 23:4 have no effect.
- R4: In a size write, bit 0 enables the window and bits 31:24 hold (length/16 MB − 1); an enabled window covers every address from base up to base + (field+1)·16 MB − 1 inclusive.
- R5: On a hit, `hit_cs` carries bits 4:2 of the matched window's size register.
- R6: When several enabled windows match, the lowest index wins; `hit_onehot` has exactly bit i set and `hit_idx` = i.
- R7: On a hit in window i, `hit_attr[3:0]` is 4'hF with bit i cleared, and `hit_attr[4]` equals `coh_en` as sampled at the same edge as the address.
- R8: On a miss, `miss` is 1 and `hit_onehot`, `hit_idx`, `hit_cs` and `hit_attr` are all 0; on a hit, `miss` is 0.
- R9: `reach_cnt` counts windows that are enabled and whose base address bits 35:32 are all zero.
- R10: `reach_list` holds the indices of the windows counted in R9 in ascending order, the first in bits 1:0 and the next in bits 3:2 and so on; unused slots are 0.
- R11: The lookup outputs change one clock after `lk_addr` is presented. A configuration write at the same edge does not affect that lookup, but does affect the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Byte offset of the register written |
| cfg_wdata | input | 32 | Write data |
| coh_en | input | 1 | Hardware coherency enable, copied into attribute bit 4 |
| lk_addr | input | 36 | Physical address to decode |
| hit_onehot | output | 4 | One-hot select of the matched window |
| hit_idx | output | 2 | Index of the matched window |
| hit_cs | output | 3 | Chip-select number stored for the matched window |
| hit_attr | output | 5 | Active-low window code in bits 3:0, coherency in bit 4 |
| miss | output | 1 | No enabled window contains the address |
| reach_cnt | output | 3 | Number of enabled windows below 4 GB |
| reach_list | output | 8 | Ascending indices of those windows, two bits each |

## Verification
A configuration write and a lookup can land on the same edge. The lookup must then see the old window state, while the status outputs and the following lookup see the new state. The bench provokes this on purpose: it disables or re-enables a window while looking up an address inside it. It also does this at random throughout a long mixed run. A behavioural model applies each write only after computing the lookup for that edge, and every clock the design is compared against the model. In the directed case, the two lookup results are judged against fixed values.

// File: rtl/dram_cs_decoder.sv
`timescale 1ns/1ps
module dram_cs_decoder #(
  parameter int NUM_WIN = 4,
  parameter int PA_W    = 36,
  localparam int IW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CAW    = IW + 3,
  localparam int CW     = $clog2(NUM_WIN + 1),
  localparam int HW     = PA_W - 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CAW-1:0]        cfg_addr,
  input  logic [31:0]           cfg_wdata,
  input  logic                  coh_en,
  input  logic [PA_W-1:0]       lk_addr,
  output logic [NUM_WIN-1:0]    hit_onehot,
  output logic [IW-1:0]         hit_idx,
  output logic [2:0]            hit_cs,
  output logic [4:0]            hit_attr,
  output logic                  miss,
  output logic [CW-1:0]         reach_cnt,
  output logic [NUM_WIN*IW-1:0] reach_list
);

  logic [7:0]    blo [NUM_WIN];
  logic [HW-1:0] bhi [NUM_WIN];
  logic [7:0]    sz  [NUM_WIN];
  logic [2:0]    csn [NUM_WIN];
  logic [NUM_WIN-1:0] en;
  logic [NUM_WIN-1:0] match;

  wire [IW-1:0] wsel    = cfg_addr[CAW-1:3];
  wire          is_size = cfg_addr[2];

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[23:5], cfg_wdata[1], cfg_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0;
      for (int i = 0; i < NUM_WIN; i++) begin
        blo[i] <= '0; bhi[i] <= '0; sz[i] <= '0; csn[i] <= '0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (wsel == IW'(i)) begin
          if (!is_size) begin
            blo[i] <= cfg_wdata[31:24];
            bhi[i] <= cfg_wdata[HW-1:0];
          end else begin
            sz[i]  <= cfg_wdata[31:24];
            csn[i] <= cfg_wdata[4:2];
            en[i]  <= cfg_wdata[0];
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [PA_W:0] lo, span, hi;
    assign lo   = {1'b0, bhi[g], blo[g], 24'd0};
    assign span = (PA_W+1)'({1'b0, sz[g]} + 9'd1) << 24;
    assign hi   = lo + span;
    assign match[g] = en[g] && ({1'b0, lk_addr} >= lo) && ({1'b0, lk_addr} < hi);
  end

  logic          found;
  logic [IW-1:0] sel;
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (match[i] && !found) begin
        found = 1'b1;
        sel   = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_onehot <= '0; hit_idx <= '0; hit_cs <= '0; hit_attr <= '0; miss <= 1'b1;
    end else if (found) begin
      hit_onehot <= NUM_WIN'(1) << sel;
      hit_idx    <= sel;
      hit_cs     <= csn[sel];
      hit_attr   <= (5'h0F & ~(5'd1 << sel)) | {coh_en, 4'b0};
      miss       <= 1'b0;
    end else begin
      hit_onehot <= '0; hit_idx <= '0; hit_cs <= '0; hit_attr <= '0; miss <= 1'b1;
    end
  end

  always_comb begin
    int k;
    k = 0;
    reach_list = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (en[i] && bhi[i] == '0) begin
        reach_list[k*IW +: IW] = IW'(i);
        k = k + 1;
      end
    end
    reach_cnt = CW'(k);
  end

  AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_onehot)); // R6
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (hit_onehot == '0 && hit_attr == '0 && hit_cs == '0 && hit_idx == '0)); // R8
  AST_HIT_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    !miss |-> hit_onehot != '0); // R8
  AST_ATTR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !miss |-> hit_attr[3:0] == (4'hF & ~4'(hit_onehot))); // R7
  AST_COH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !miss |=> (miss || hit_attr[4] == $past(coh_en))); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    reach_cnt <= CW'(NUM_WIN)); // R9

endmodule

// File: tb/dram_cs_decoder_test.sv
`timescale 1ns/1ps
module dram_cs_decoder_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        coh_en = 0;
  logic [35:0] lk_addr = '0;
  logic [3:0]  hit_onehot;
  logic [1:0]  hit_idx;
  logic [2:0]  hit_cs;
  logic [4:0]  hit_attr;
  logic        miss;
  logic [2:0]  reach_cnt;
  logic [7:0]  reach_list;

  int checks = 0;
  int fails  = 0;
  bit live   = 0;

  dram_cs_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .coh_en(coh_en), .lk_addr(lk_addr),
    .hit_onehot(hit_onehot), .hit_idx(hit_idx), .hit_cs(hit_cs),
    .hit_attr(hit_attr), .miss(miss), .reach_cnt(reach_cnt),
    .reach_list(reach_list)
  );

  always #4 clk = ~clk;

  logic [7:0] m_blo [4];
  logic [3:0] m_bhi [4];
  logic [7:0] m_sz  [4];
  logic [2:0] m_cs  [4];
  bit         m_en  [4];
  logic [3:0] e_oh;
  logic [1:0] e_idx;
  logic [2:0] e_cs;
  logic [4:0] e_attr;
  logic       e_miss;
  longint unsigned lo, hi, a;
  int w;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_blo[i] = 0; m_bhi[i] = 0; m_sz[i] = 0; m_cs[i] = 0; m_en[i] = 0;
      end
      e_oh = 0; e_idx = 0; e_cs = 0; e_attr = 0; e_miss = 1;
    end else begin
      w = -1;
      a = longint'(lk_addr);
      for (int i = 0; i < 4; i++) begin
        lo = (longint'(m_bhi[i]) << 32) | (longint'(m_blo[i]) << 24);
        hi = lo + ((longint'(m_sz[i]) + 1) << 24);
        if (w < 0 && m_en[i] && a >= lo && a < hi) w = i;
      end
      if (w < 0) begin
        e_oh = 0; e_idx = 0; e_cs = 0; e_attr = 0; e_miss = 1;
      end else begin
        e_oh = 4'(1 << w); e_idx = 2'(w); e_cs = m_cs[w];
        e_attr = {coh_en, 4'hF & ~4'(1 << w)}; e_miss = 0;
      end
      if (cfg_we) begin
        if (!cfg_addr[2]) begin
          m_blo[cfg_addr[4:3]] = cfg_wdata[31:24];
          m_bhi[cfg_addr[4:3]] = cfg_wdata[3:0];
        end else begin
          m_sz[cfg_addr[4:3]] = cfg_wdata[31:24];
          m_cs[cfg_addr[4:3]] = cfg_wdata[4:2];
          m_en[cfg_addr[4:3]] = cfg_wdata[0];
        end
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && live) begin
      int q[$];
      logic [7:0] el;
      q = {};
      for (int i = 0; i < 4; i++) if (m_en[i] && m_bhi[i] == 0) q.push_back(i);
      el = 0;
      foreach (q[k]) el[k*2 +: 2] = 2'(q[k]);
      chk("R6 onehot", hit_onehot, e_oh);
      chk("R6 index", hit_idx, e_idx);
      chk("R5 cs", hit_cs, e_cs);
      chk("R7 attr", hit_attr, e_attr);
      chk("R8 miss", miss, e_miss);
      chk("R9 count", reach_cnt, q.size());
      chk("R10 list", reach_list, el);
    end
  end

  task automatic wr(input logic [4:0] ad, input logic [31:0] d);
    cfg_we = 1; cfg_addr = ad; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic look(input logic [35:0] ad);
    lk_addr = ad;
    @(negedge clk);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1200000;
    fails++;
    $display("FAIL watchdog expired (R11 timing) actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1; live = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 miss", miss, 1);
    chk("R1 onehot", hit_onehot, 0);
    chk("R1 count", reach_cnt, 0);
    chk("R1 list", reach_list, 0);
    // R2/R3: window 1 base at offset 8, junk in data bits 23:4
    wr(5'd8, 32'h40AB_CDE0);
    wr(5'd12, 32'h0F00_0015); // R4: 256 MB, cs 5, enabled
    look(36'h0_4000_0000);
    chk("R3 base hit", hit_onehot, 4'b0010);
    chk("R5 cs value", hit_cs, 5);
    chk("R7 attr win1", hit_attr, 5'h0D);
    coh_en = 1;
    look(36'h0_4FFF_FFFF);
    chk("R4 last byte", hit_onehot, 4'b0010);
    chk("R7 coherency", hit_attr, 5'h1D);
    coh_en = 0;
    look(36'h0_5000_0000);
    chk("R4 past end", miss, 1);
    look(36'h0_3FFF_FFFF);
    chk("R8 below base", hit_attr, 0);
    // R6: window 0 overlaps inside window 1
    wr(5'd0, 32'h4800_0000);
    wr(5'd4, 32'h0000_0009);
    look(36'h0_4800_0000);
    chk("R6 lowest wins", hit_idx, 0);
    chk("R7 attr win0", hit_attr, 5'h0E);
    look(36'h0_4900_0000);
    chk("R6 fallthrough", hit_idx, 1);
    chk("R10 two", reach_list, 8'h04);
    // R9: window 3 above 4 GB not counted but decodes
    wr(5'd24, 32'h1000_0001);
    wr(5'd28, 32'h0000_0001);
    look(36'h1_1000_0000);
    chk("R3 high base hit", hit_idx, 3);
    chk("R9 high excluded", reach_cnt, 2);
    wr(5'd16, 32'h2000_0000);
    wr(5'd22, 32'h0000_0001); // R2: low address bits ignored
    chk("R10 three", reach_list, 8'h24);
    chk("R2 count", reach_cnt, 3);
    wr(5'd4, 32'h0000_0000);
    chk("R10 after disable", reach_list, 8'h09);
    // R11: re-enable window 0 at the same edge as a lookup inside it
    cfg_we = 1; cfg_addr = 5'd4; cfg_wdata = 32'h0000_0009; lk_addr = 36'h0_4800_0000;
    @(negedge clk);
    cfg_we = 0;
    chk("R11 old state", hit_onehot, 4'b0010);
    @(negedge clk);
    chk("R11 new state", hit_onehot, 4'b0001);
    // mixed random traffic, compared every clock against the model
    for (int n = 0; n < 3000; n++) begin
      cfg_we = ($urandom % 4) == 0;
      cfg_addr = 5'($urandom);
      cfg_wdata = $urandom;
      if (!cfg_addr[2]) begin
        cfg_wdata[31:24] = 8'h10 + 8'($urandom % 4);
        cfg_wdata[3:0] = (($urandom % 5) == 0) ? 4'h1 : 4'h0;
      end else begin
        cfg_wdata[31:24] = 8'($urandom % 4);
      end
      coh_en = 1'($urandom);
      lk_addr = {4'(($urandom % 6) == 0), 8'h10 + 8'($urandom % 6), 24'($urandom)};
      @(negedge clk);
    end
    cfg_we = 0;
    @(negedge clk);
    finish_up();
  end
endmodule